// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter Timer

A 32-bit timer that counts down from a programmable start value at a rate set by a clock-source selector and a 12-bit divider. Whenever the counter equals a programmable compare value on a count step, a sticky event flag is raised. The counter then restarts from the start value (periodic mode) or keeps going from all ones (free-running mode). A single interrupt line is the event flag gated by an interrupt-enable bit.

Software reaches the timer through a flat, word-indexed register port. A write is one clock cycle with `reg_wr` high. Reads are combinational from `reg_sel`. The two tick inputs are single-cycle enables from the surrounding clock tree: one is fast and one is slow. Each count step advances the timer by one.

Top module: `pit_top`

## Requirements
- R1: After hardware reset, and after a control write with bit 16 set, the control and compare registers read 0, the flag is 0, and the load register and counter read 0xFFFFFFFF. Counting stops and bit 16 never reads back as 1.
- R2: Index 0 reads control, 1 reads the flag in bit 0, 2 reads load, 3 reads compare and 4 reads the counter. A control write stores the written value with bits 31:26 and bit 16 forced to 0.
- R3: A control write that sets enable (bit 0) while it was clear loads the counter from the load register if enable mode (bit 1) is 0. It keeps the counter if enable mode is 1. A write that leaves enable set does not reload.
- R4: While enable is 0, the counter does not change with any tick.
- R5: With prescaler value P in bits 15:4, the counter steps once every P+1 selected ticks. After a software reset, the first step falls on the (P+1)-th tick.
- R6: Clock select bits 25:24 choose the tick: code 0 gives no ticks, codes 1 and 2 select `tick_main`, and code 3 selects `tick_slow`.
- R7: A step with counter equal to compare sets the flag. With reload mode (bit 3) at 1, the counter becomes the load value.
- R8: With reload mode at 0, such a step makes the counter 0xFFFFFFFF.
- R9: A write to index 2 while load-overwrite (bit 17) is 1 also sets the counter to the written value in the same cycle. With bit 17 at 0, the counter is unchanged.
- R10: Any write to index 1 clears the flag, unless a compare event happens in the same cycle; then the flag ends up set.
- R11: `irq` equals the flag AND control bit 2.
- R12: Writes to index 4 do not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_main | input | 1 | Fast tick enable |
| tick_slow | input | 1 | Slow tick enable |
| reg_sel | input | 3 | Register word index |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_sel` |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the cycle in which a flag set and a flag clear collide. A design that lets the clear win would lose a period. It checks that rewriting control while enabled does not reload; a design that reloads on every write would stretch the period. It also checks that free-running mode jumps to all ones rather than to the load value. Prescaler phase and clock-source masking are also checked: an off-by-one divider shows up as a wrong count after exactly P+1 ticks, and a broken select shows up as counting on the wrong tick input.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W = 32;
  localparam int PSC_W  = 12;
  localparam int IDX_W  = 3;
  localparam int SRC_W  = 2;

  // control bit positions
  localparam int CB_EN      = 0;
  localparam int CB_ENMODE  = 1;
  localparam int CB_IEN     = 2;
  localparam int CB_RELOAD  = 3;
  localparam int CB_PSC_LSB = 4;
  localparam int CB_SWRST   = 16;
  localparam int CB_OVWR    = 17;
  localparam int CB_SRC_LSB = 24;
  localparam int CB_TOP_LSB = 26;

  // register word indices
  localparam logic [IDX_W-1:0] IX_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] IX_STAT = 3'd1;
  localparam logic [IDX_W-1:0] IX_LOAD = 3'd2;
  localparam logic [IDX_W-1:0] IX_CMP  = 3'd3;
  localparam logic [IDX_W-1:0] IX_CNT  = 3'd4;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE  = 2'd0,
    SRC_MAIN  = 2'd1,
    SRC_MAIN2 = 2'd2,
    SRC_SLOW  = 2'd3
  } src_e;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          evt,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] load_q,
  output logic [DW-1:0] cmp_q,
  output logic          flag_q,
  output logic          swr,
  output logic          cnt_set,
  output logic [DW-1:0] cnt_set_val
);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};
  localparam logic [DW-1:0] WMASK =
    ~(((ONES >> CB_TOP_LSB) << CB_TOP_LSB) | (DW'(1) << CB_SWRST));

  logic wr_ctrl, wr_stat, wr_load, wr_cmp, en_rise;
  logic [DW-1:0] ctrl_d, load_d, cmp_d;
  logic flag_d;
  logic ctrl_ce, load_ce, cmp_ce;

  always_comb begin
    wr_ctrl = reg_wr && (reg_sel == IX_CTRL);
    wr_stat = reg_wr && (reg_sel == IX_STAT);
    wr_load = reg_wr && (reg_sel == IX_LOAD);
    wr_cmp  = reg_wr && (reg_sel == IX_CMP);
    swr     = wr_ctrl && reg_wdata[CB_SWRST];
    en_rise = wr_ctrl && !swr && reg_wdata[CB_EN] && !ctrl_q[CB_EN]
              && !reg_wdata[CB_ENMODE];

    ctrl_ce = wr_ctrl;
    ctrl_d  = swr ? '0 : (reg_wdata & WMASK);

    load_ce = swr || wr_load;
    load_d  = swr ? ONES : reg_wdata;

    cmp_ce  = swr || wr_cmp;
    cmp_d   = swr ? '0 : reg_wdata;

    if (swr)          flag_d = 1'b0;
    else if (evt)     flag_d = 1'b1;
    else if (wr_stat) flag_d = 1'b0;
    else              flag_d = flag_q;

    cnt_set = swr || (wr_load && ctrl_q[CB_OVWR]) || en_rise;
    if (swr)          cnt_set_val = ONES;
    else if (wr_load) cnt_set_val = reg_wdata;
    else              cnt_set_val = load_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= ONES;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (load_ce) load_q <= load_d;
      if (cmp_ce)  cmp_q  <= cmp_d;
      flag_q <= flag_d;
    end
  end

  // R10: a status write alone clears the flag
  p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !evt) |=> !flag_q);
  // R10: a compare event sets the flag even against a status write
  p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !swr) |=> flag_q);
  // R1: software reset restores register defaults
  p_swrst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (ctrl_q == '0) && (&load_q) && (cmp_q == '0) && !flag_q);
  // R2: reserved control bits never become set
  p_ctrl_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q[DW-1:CB_TOP_LSB] == '0) && !ctrl_q[CB_SWRST]);
endmodule

// File: rtl/pit_prescale.sv
module pit_prescale
  import pit_pkg::*;
#(
  parameter int PW = PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [PW-1:0]    psc,
  input  logic             tick_main,
  input  logic             tick_slow,
  output logic             ctick
);
  logic          src_tick;
  logic [PW-1:0] pre_q, pre_d;
  logic          pre_ce, at_end;

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_NONE:  src_tick = 1'b0;
      SRC_MAIN,
      SRC_MAIN2: src_tick = tick_main;
      SRC_SLOW:  src_tick = tick_slow;
      default:   src_tick = 1'b0;
    endcase
    at_end = (pre_q >= psc);
    ctick  = en && src_tick && at_end;
    pre_ce = clr || (en && src_tick);
    if (clr || at_end) pre_d = '0;
    else               pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_ce) pre_q <= pre_d;
  end

  // R6: a count step needs an enabled, selected tick
  p_step_needs_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctick |-> (en && ((src_sel == SRC_SLOW) ? tick_slow :
                      (src_sel != SRC_NONE) && tick_main)));
  // R5: the phase counter stays idle without an enabled tick
  p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(en && src_tick)) |=> $stable(pre_q));
endmodule

// File: rtl/pit_count.sv
module pit_count
  import pit_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctick,
  input  logic          reload_mode,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] cmp_val,
  input  logic          cnt_set,
  input  logic [DW-1:0] cnt_set_val,
  output logic [DW-1:0] cnt_q,
  output logic          evt
);
  logic [DW-1:0] cnt_d;
  logic          cnt_ce;

  always_comb begin
    evt    = ctick && (cnt_q == cmp_val);
    cnt_ce = cnt_set || ctick;
    if (cnt_set)  cnt_d = cnt_set_val;
    else if (evt) cnt_d = reload_mode ? load_val : {DW{1'b1}};
    else          cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= {DW{1'b1}};
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R4: no step and no load means the counter holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctick && !cnt_set) |=> $stable(cnt_q));
  // R5: a plain step decrements by one
  p_decr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctick && !cnt_set && (cnt_q != cmp_val)) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R7: periodic restart from the load value
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctick && !cnt_set && (cnt_q == cmp_val) && reload_mode) |=> (cnt_q == $past(load_val)));
  // R8: free-running wrap to all ones
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctick && !cnt_set && (cnt_q == cmp_val) && !reload_mode) |=> (&cnt_q));
endmodule

// File: rtl/pit_top.sv
module pit_top
  import pit_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W,
  parameter int PW = PSC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_main,
  input  logic          tick_slow,
  input  logic [IW-1:0] reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [1:0]    rst_sync;
  logic          rst_s_n;
  logic [DW-1:0] ctrl_q, load_q, cmp_q, cnt_q, cnt_set_val;
  logic          flag_q, swr, cnt_set, evt, ctick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  pit_regs #(.DW(DW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .evt(evt), .ctrl_q(ctrl_q), .load_q(load_q),
    .cmp_q(cmp_q), .flag_q(flag_q), .swr(swr), .cnt_set(cnt_set),
    .cnt_set_val(cnt_set_val)
  );

  pit_prescale #(.PW(PW)) u_psc (
    .clk(clk), .rst_n(rst_s_n), .clr(swr), .en(ctrl_q[CB_EN]),
    .src_sel(ctrl_q[CB_SRC_LSB +: SRC_W]), .psc(ctrl_q[CB_PSC_LSB +: PW]),
    .tick_main(tick_main), .tick_slow(tick_slow), .ctick(ctick)
  );

  pit_count #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .ctick(ctick), .reload_mode(ctrl_q[CB_RELOAD]),
    .load_val(load_q), .cmp_val(cmp_q), .cnt_set(cnt_set),
    .cnt_set_val(cnt_set_val), .cnt_q(cnt_q), .evt(evt)
  );

  always_comb begin
    unique case (reg_sel)
      IX_CTRL: reg_rdata = ctrl_q;
      IX_STAT: reg_rdata = {{(DW-1){1'b0}}, flag_q};
      IX_LOAD: reg_rdata = load_q;
      IX_CMP:  reg_rdata = cmp_q;
      IX_CNT:  reg_rdata = cnt_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag_q && ctrl_q[CB_IEN];

  // R12: a write to the counter index alone leaves the counter alone
  p_cnt_ro_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_wr && (reg_sel == IX_CNT) && !ctick) |=> $stable(cnt_q));
  // R11: the interrupt drops when its enable is cleared
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_wr && (reg_sel == IX_CTRL) && !reg_wdata[CB_IEN]) |=> !irq);
endmodule

// File: tb/sim_pit_top.sv
module sim_pit_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_main = 1'b0, tick_slow = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] EN = 32'h1, ENMODE = 32'h2, IEN = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SWR = 32'h1_0000, OVW = 32'h2_0000;
  localparam logic [31:0] S0 = 32'h0, S1 = 32'h0100_0000, S2 = 32'h0200_0000,
                          S3 = 32'h0300_0000;

  always #4 clk = ~clk;

  pit_top u0 (.clk(clk), .rst_n(rst_n), .tick_main(tick_main), .tick_slow(tick_slow),
              .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
              .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_sel = idx; reg_wdata = val; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    reg_sel = idx;
    #1;
    val = reg_rdata;
  endtask

  task automatic ticks(input bit slow, input int n);
    @(negedge clk);
    if (slow) tick_slow = 1'b1; else tick_main = 1'b1;
    repeat (n) @(negedge clk);
    tick_main = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    rd(0, v); chk("R1 ctrl", v, 32'h0);
    rd(1, v); chk("R1 flag", v, 32'h0);
    rd(2, v); chk("R1 load", v, 32'hFFFF_FFFF);
    rd(3, v); chk("R1 cmp", v, 32'h0);
    rd(4, v); chk("R1 cnt", v, 32'hFFFF_FFFF);
    chk("R11 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_swreset;
    logic [31:0] v;
    wr(2, 32'h55); wr(3, 32'h7); wr(0, EN | IEN | S1);
    wr(0, SWR | EN);
    rd(0, v); chk("R1 swr ctrl self-clear", v, 32'h0);
    rd(2, v); chk("R1 swr load", v, 32'hFFFF_FFFF);
    rd(3, v); chk("R1 swr cmp", v, 32'h0);
    rd(4, v); chk("R1 swr cnt", v, 32'hFFFF_FFFF);
    ticks(0, 3);
    rd(4, v); chk("R1 swr stops counting", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_ctrl_mask;
    logic [31:0] v;
    wr(0, SWR);
    wr(0, 32'hFFFE_FFFF);
    rd(0, v); chk("R2 ctrl mask", v, 32'h03FE_FFFF);
    wr(0, SWR);
  endtask

  task automatic t_enable_modes;
    logic [31:0] v;
    wr(0, SWR);
    wr(2, 32'd10);
    rd(4, v); chk("R9 load write without overwrite", v, 32'hFFFF_FFFF);
    wr(0, EN | S1);
    rd(4, v); chk("R3 enable loads counter", v, 32'd10);
    ticks(0, 3);
    rd(4, v); chk("R5 count down prescale 0", v, 32'd7);
    wr(0, EN | S1 | IEN);
    rd(4, v); chk("R3 no reload when already enabled", v, 32'd7);
    wr(0, S1);
    ticks(0, 4);
    rd(4, v); chk("R4 hold while disabled", v, 32'd7);
    wr(0, EN | ENMODE | S1);
    rd(4, v); chk("R3 enable mode keeps counter", v, 32'd7);
    wr(0, S1);
    wr(0, EN | S1);
    rd(4, v); chk("R3 re-enable reloads", v, 32'd10);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(0, SWR);
    wr(2, 32'd3); wr(3, 32'd0);
    wr(0, EN | IEN | RLD | S1);
    ticks(0, 3);
    rd(4, v); chk("R7 reaches compare", v, 32'd0);
    rd(1, v); chk("R7 flag clear before event", v, 32'd0);
    ticks(0, 1);
    rd(4, v); chk("R7 periodic reload", v, 32'd3);
    rd(1, v); chk("R7 flag set", v, 32'd1);
    chk("R11 irq with enable", {31'b0, irq}, 32'd1);
    wr(0, EN | RLD | S1);
    chk("R11 irq gated off", {31'b0, irq}, 32'd0);
    wr(0, EN | IEN | RLD | S1);
    chk("R11 irq gated on", {31'b0, irq}, 32'd1);
    wr(1, 32'h0);
    rd(1, v); chk("R10 status write clears", v, 32'd0);
    chk("R11 irq follows clear", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_freerun;
    logic [31:0] v;
    wr(0, SWR);
    wr(2, 32'd5); wr(3, 32'd2);
    wr(0, EN | S1);
    ticks(0, 3);
    rd(4, v); chk("R8 before compare", v, 32'd2);
    ticks(0, 1);
    rd(4, v); chk("R8 wrap to all ones", v, 32'hFFFF_FFFF);
    rd(1, v); chk("R8 flag set", v, 32'd1);
    ticks(0, 2);
    rd(4, v); chk("R8 continues down", v, 32'hFFFF_FFFD);
  endtask

  task automatic t_overwrite_ro;
    logic [31:0] v;
    wr(0, SWR);
    wr(2, 32'd9);
    wr(0, EN | OVW | S1);
    wr(2, 32'h20);
    rd(4, v); chk("R9 overwrite loads counter", v, 32'h20);
    rd(2, v); chk("R9 load register updated", v, 32'h20);
    wr(4, 32'h1234);
    rd(4, v); chk("R12 counter read-only", v, 32'h20);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(0, SWR);
    wr(2, 32'd100);
    wr(0, EN | (32'd2 << 4) | S1);
    ticks(0, 2);
    rd(4, v); chk("R5 no step before P+1 ticks", v, 32'd100);
    ticks(0, 1);
    rd(4, v); chk("R5 step on tick P+1", v, 32'd99);
    ticks(0, 3);
    rd(4, v); chk("R5 second step", v, 32'd98);
  endtask

  task automatic t_clksel;
    logic [31:0] v;
    wr(0, SWR);
    wr(2, 32'd50);
    wr(0, EN | S0);
    ticks(0, 4); ticks(1, 4);
    rd(4, v); chk("R6 code 0 no clock", v, 32'd50);
    wr(0, EN | S3);
    ticks(0, 4);
    rd(4, v); chk("R6 code 3 ignores main", v, 32'd50);
    ticks(1, 4);
    rd(4, v); chk("R6 code 3 uses slow", v, 32'd46);
    wr(0, EN | S2);
    ticks(1, 3);
    rd(4, v); chk("R6 code 2 ignores slow", v, 32'd46);
    ticks(0, 3);
    rd(4, v); chk("R6 code 2 uses main", v, 32'd43);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(0, SWR);
    wr(2, 32'd2); wr(3, 32'd2);
    wr(0, EN | S1);
    @(negedge clk);
    reg_sel = 3'd1; reg_wdata = '0; reg_wr = 1'b1; tick_main = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_main = 1'b0;
    rd(1, v); chk("R10 event beats status write", v, 32'd1);
    rd(4, v); chk("R8 collide wrap", v, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_swreset();
    t_ctrl_mask();
    t_enable_modes();
    t_periodic();
    t_freerun();
    t_overwrite_ro();
    t_prescale();
    t_clksel();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule